// File: doc/BRIEF.md
# Single-Precision Min/Max, Sign-Injection and Classify Unit

This unit handles the non-arithmetic binary32 operations of a floating-point pipeline: minimum, maximum, the three sign-injection forms, and classification. Each operand arrives in a wide lane (64 bits by default). A binary32 value counts as valid only when every bit above bit 31 is one. When that boxing check is on, any other pattern is read as the canonical quiet NaN.

Floating-point results leave with their upper bits set to ones. The classification result is a 32-bit integer, sign-extended to the lane width. Minimum and maximum follow the IEEE-754-2019 minimumNumber/maximumNumber rules, and they are the only operations that can raise the invalid flag.

The unit has one register stage between a valid/ready input and a valid/ready output. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained on that same edge. While `out_valid` is high and `out_ready` is low, the output holds its value and no new operation is taken in. A full register that is drained on an edge can accept a new operation on that edge, so back-to-back throughput is one operation per cycle.

Top module: `fp32_misc_unit`

## Requirements
- R1: An operation accepted on an edge appears at the output with `out_valid` high after that same edge. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. An output drained with no new acceptance leaves `out_valid` low.
- R2: While `out_valid` is high and `out_ready` is low, `out_result` and `out_invalid` hold their values and `in_ready` is low.
- R3: `in_op` 0 selects minimum and 1 selects maximum. Operands are ordered by value, and -0.0 ranks below +0.0.
- R4: If both min/max operands are NaN, the result is the canonical NaN 32'h7FC00000.
- R5: If exactly one min/max operand is NaN, the result is the other operand.
- R6: A signaling NaN on either min/max operand (exponent all ones, mantissa nonzero, mantissa bit 22 clear) sets `out_invalid`, even when the result is a number. Quiet NaNs do not set it.
- R7: An operand whose bits 63:32 are not all ones is treated as the canonical quiet NaN.
- R8: Every floating-point result (ops 0 to 4) has bits 63:32 all ones.
- R9: `in_op` 2, 3 and 4 return operand a's bits 30:0 with a sign taken from b's sign, from the inverse of b's sign, or from the XOR of both signs. They never set `out_invalid`, and NaN payloads pass through unchanged.
- R10: `in_op` 5 returns a one-hot 10-bit mask of operand a. Bits 0 to 9 are: -inf, -normal, -subnormal, -0, +0, +subnormal, +normal, +inf, signaling NaN, quiet NaN. All other result bits are zero, and `out_invalid` is low.
- R11: After reset, `out_valid` is low and `in_ready` is high.
- R12: `in_op` 6 and 7 return an all-zero result with `out_invalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | 64 | Operand a (boxed binary32) |
| in_b | input | 64 | Operand b (boxed binary32) |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Boxed FP result or sign-extended integer |
| out_invalid | output | 1 | Invalid-operation flag for this result |

## Verification
The hardest state to reach is a stalled output register with a second operation already waiting at the input. That is the only case where R2's hold and R1's simultaneous drain-and-accept can be seen. The bench reaches it with a directed sequence: it lowers `out_ready` after one acceptance and keeps a new operation presented for several cycles. It then raises `out_ready` for a single edge and checks that the first result leaves and the second is captured on that same edge. Signaling NaNs paired with numbers, and badly boxed operands, are rare under uniform random bits. The random generator therefore draws operands from a weighted pool of special encodings and corrupts the upper half of an operand in about one draw in eight.

// File: rtl/fp32_misc_pkg.sv
package fp32_misc_pkg;

  typedef enum logic [2:0] {
    OP_MIN   = 3'd0,
    OP_MAX   = 3'd1,
    OP_SGNJ  = 3'd2,
    OP_SGNJN = 3'd3,
    OP_SGNJX = 3'd4,
    OP_CLASS = 3'd5
  } op_e;

  localparam int unsigned F32_W   = 32;
  localparam int unsigned CLASS_W = 10;
  localparam logic [F32_W-1:0] CANON_NAN = 32'h7FC0_0000;

  typedef struct packed {
    logic        sign;
    logic [7:0]  exp;
    logic [22:0] man;
  } f32_t;

endpackage

// File: rtl/fp32_unbox.sv
module fp32_unbox
  import fp32_misc_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter bit          BOX_CHECK = 1'b1
) (
  input  logic [DATA_W-1:0] raw,
  output logic [F32_W-1:0]  val,
  output logic              is_nan,
  output logic              is_snan
);
  localparam int unsigned UPPER_W = DATA_W - F32_W;

  logic boxed;
  f32_t f;

  generate
    if (BOX_CHECK && UPPER_W > 0) begin : g_check
      assign boxed = &raw[DATA_W-1:F32_W];
    end else begin : g_nocheck
      assign boxed = 1'b1;
    end
  endgenerate

  assign val = boxed ? raw[F32_W-1:0] : CANON_NAN;
  assign f   = f32_t'(val);

  always_comb begin
    is_nan  = (f.exp == 8'hFF) && (f.man != '0);
    is_snan = is_nan && !f.man[22];
  end
endmodule

// File: rtl/fp32_classify.sv
module fp32_classify
  import fp32_misc_pkg::*;
(
  input  logic [F32_W-1:0]   val,
  output logic [CLASS_W-1:0] mask
);
  f32_t f;
  logic exp_max, exp_zero, man_zero;

  assign f        = f32_t'(val);
  assign exp_max  = (f.exp == 8'hFF);
  assign exp_zero = (f.exp == 8'h00);
  assign man_zero = (f.man == '0);

  always_comb begin
    mask = '0;
    if (exp_max) begin
      if (man_zero)       mask[f.sign ? 0 : 7] = 1'b1;
      else if (f.man[22]) mask[9] = 1'b1;
      else                mask[8] = 1'b1;
    end else if (exp_zero) begin
      if (man_zero) mask[f.sign ? 3 : 4] = 1'b1;
      else          mask[f.sign ? 2 : 5] = 1'b1;
    end else begin
      mask[f.sign ? 1 : 6] = 1'b1;
    end
  end
endmodule

// File: rtl/fp32_minmax.sv
module fp32_minmax
  import fp32_misc_pkg::*;
(
  input  logic [F32_W-1:0] a,
  input  logic [F32_W-1:0] b,
  input  logic             a_nan,
  input  logic             b_nan,
  input  logic             a_snan,
  input  logic             b_snan,
  input  logic             want_max,
  output logic [F32_W-1:0] res,
  output logic             invalid
);
  // Map sign-magnitude onto an unsigned total order (-0 below +0).
  function automatic logic [F32_W-1:0] order_key(input logic [F32_W-1:0] v);
    return v[F32_W-1] ? ~v : (v | 32'h8000_0000);
  endfunction

  logic a_below_b;
  assign a_below_b = order_key(a) < order_key(b);

  always_comb begin
    if (a_nan && b_nan)   res = CANON_NAN;
    else if (a_nan)       res = b;
    else if (b_nan)       res = a;
    else if (want_max)    res = a_below_b ? b : a;
    else                  res = a_below_b ? a : b;
    invalid = a_snan || b_snan;
  end
endmodule

// File: rtl/fp32_sgnj.sv
module fp32_sgnj
  import fp32_misc_pkg::*;
(
  input  logic [F32_W-1:0] a,
  input  logic [F32_W-1:0] b,
  input  op_e              op,
  output logic [F32_W-1:0] res
);
  logic new_sign;
  always_comb begin
    case (op)
      OP_SGNJN: new_sign = ~b[F32_W-1];
      OP_SGNJX: new_sign = a[F32_W-1] ^ b[F32_W-1];
      default:  new_sign = b[F32_W-1];
    endcase
    res = {new_sign, a[F32_W-2:0]};
  end
endmodule

// File: rtl/fp32_misc_unit.sv
module fp32_misc_unit
  import fp32_misc_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter bit          BOX_CHECK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_invalid
);
  localparam int unsigned UPPER_W = DATA_W - F32_W;

  op_e op;
  assign op = op_e'(in_op);

  logic [F32_W-1:0]   a_val, b_val, mm_res, sj_res, r32;
  logic               a_nan, b_nan, a_snan, b_snan, mm_inv, inv_d, is_fp;
  logic [CLASS_W-1:0] cls_mask;
  logic [DATA_W-1:0]  res_d;

  fp32_unbox #(.DATA_W(DATA_W), .BOX_CHECK(BOX_CHECK)) u_unbox_a (
    .raw(in_a), .val(a_val), .is_nan(a_nan), .is_snan(a_snan));
  fp32_unbox #(.DATA_W(DATA_W), .BOX_CHECK(BOX_CHECK)) u_unbox_b (
    .raw(in_b), .val(b_val), .is_nan(b_nan), .is_snan(b_snan));

  fp32_minmax u_minmax (
    .a(a_val), .b(b_val), .a_nan(a_nan), .b_nan(b_nan),
    .a_snan(a_snan), .b_snan(b_snan), .want_max(op == OP_MAX),
    .res(mm_res), .invalid(mm_inv));

  fp32_sgnj u_sgnj (.a(a_val), .b(b_val), .op(op), .res(sj_res));

  fp32_classify u_class (.val(a_val), .mask(cls_mask));

  always_comb begin
    r32   = '0;
    inv_d = 1'b0;
    is_fp = 1'b0;
    case (op)
      OP_MIN, OP_MAX: begin
        r32 = mm_res; inv_d = mm_inv; is_fp = 1'b1;
      end
      OP_SGNJ, OP_SGNJN, OP_SGNJX: begin
        r32 = sj_res; is_fp = 1'b1;
      end
      OP_CLASS: r32 = {{(F32_W-CLASS_W){1'b0}}, cls_mask};
      default: ;
    endcase
    res_d = is_fp ? {{UPPER_W{1'b1}}, r32} : {{UPPER_W{r32[F32_W-1]}}, r32};
  end

  // One-deep output register with pass-through ready.
  logic accept;
  op_e  op_q;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      op_q        <= OP_MIN;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= res_d;
      out_invalid <= inv_d;
      op_q        <= op;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_invalid));

  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_boxed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q inside {OP_MIN, OP_MAX, OP_SGNJ, OP_SGNJN, OP_SGNJX})
    |-> &out_result[DATA_W-1:F32_W]);

  p_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q inside {OP_SGNJ, OP_SGNJN, OP_SGNJX, OP_CLASS}) |-> !out_invalid);

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == OP_CLASS |-> $onehot(out_result[CLASS_W-1:0]));
endmodule

// File: tb/fp32_misc_unit_test.sv
module fp32_misc_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CNAN = 32'h7FC0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, out_invalid;
  logic [2:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0, out_result;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_misc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_invalid(out_invalid));

  function automatic logic [31:0] unbox(input logic [63:0] x);
    return (x[63:32] == 32'hFFFF_FFFF) ? x[31:0] : CNAN;
  endfunction
  function automatic bit isnan(input logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction
  function automatic bit issnan(input logic [31:0] v);
    return isnan(v) && !v[22];
  endfunction
  function automatic bit lessthan(input logic [31:0] x, input logic [31:0] y);
    if (x[31] != y[31]) return x[31];
    if (!x[31]) return x[30:0] < y[30:0];
    return x[30:0] > y[30:0];
  endfunction
  function automatic logic [9:0] cls(input logic [31:0] v);
    logic [9:0] m = '0;
    if (v[30:23] == 8'hFF) begin
      if (v[22:0] == 0) m[v[31] ? 0 : 7] = 1;
      else if (v[22]) m[9] = 1; else m[8] = 1;
    end else if (v[30:23] == 0) begin
      if (v[22:0] == 0) m[v[31] ? 3 : 4] = 1; else m[v[31] ? 2 : 5] = 1;
    end else m[v[31] ? 1 : 6] = 1;
    return m;
  endfunction

  // Returns {invalid, result}
  function automatic logic [64:0] model(input logic [2:0] op, input logic [63:0] ra, input logic [63:0] rb);
    logic [31:0] a = unbox(ra), b = unbox(rb), r;
    case (op)
      3'd0, 3'd1: begin
        if (isnan(a) && isnan(b)) r = CNAN;
        else if (isnan(a)) r = b;
        else if (isnan(b)) r = a;
        else if (op == 3'd0) r = lessthan(b, a) ? b : a;
        else r = lessthan(a, b) ? b : a;
        return {issnan(a) || issnan(b), 32'hFFFF_FFFF, r};
      end
      3'd2: return {1'b0, 32'hFFFF_FFFF, b[31], a[30:0]};
      3'd3: return {1'b0, 32'hFFFF_FFFF, ~b[31], a[30:0]};
      3'd4: return {1'b0, 32'hFFFF_FFFF, a[31] ^ b[31], a[30:0]};
      3'd5: return {1'b0, 54'd0, cls(a)};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input bit ok, input logic [64:0] got, input logic [64:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_one(input string tag, input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [64:0] exp;
    @(negedge clk);
    in_valid = 1; in_op = op; in_a = a; in_b = b; out_ready = 1;
    exp = model(op, a, b);
    @(negedge clk);
    in_valid = 0;
    check(tag, out_valid && {out_invalid, out_result} == exp, {out_invalid, out_result}, exp);
  endtask

  function automatic logic [31:0] pick32();
    case ($urandom % 12)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7F80_0000;
      3: return 32'hFF80_0000;
      4: return 32'h7FC0_0000 | ($urandom & 32'h803F_FFFF);
      5: return 32'h7F80_0001 | ($urandom & 32'h801F_FFFF);
      6: return $urandom & 32'h807F_FFFF;
      default: return $urandom;
    endcase
  endfunction
  function automatic logic [63:0] pick64();
    logic [31:0] up = (($urandom % 8) == 0) ? $urandom : 32'hFFFF_FFFF;
    return {up, pick32()};
  endfunction

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  initial begin
    logic [64:0] e1, e2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11 reset out_valid", out_valid == 0, {64'd0, out_valid}, 65'd0);
    check("R11 reset in_ready", in_ready == 1, {64'd0, in_ready}, 65'd1);
    rst_n = 1;

    run_one("R3 min -0/+0", 3'd0, {ONES, 32'h0000_0000}, {ONES, 32'h8000_0000});
    run_one("R3 max -0/+0", 3'd1, {ONES, 32'h8000_0000}, {ONES, 32'h0000_0000});
    run_one("R3 min 1/2",   3'd0, {ONES, 32'h4000_0000}, {ONES, 32'h3F80_0000});
    run_one("R3 max -1/-2", 3'd1, {ONES, 32'hC000_0000}, {ONES, 32'hBF80_0000});
    run_one("R4 both NaN",  3'd1, {ONES, 32'h7FC0_1234}, {ONES, 32'hFF80_0005});
    run_one("R5 one qNaN",  3'd0, {ONES, 32'h7FC0_0000}, {ONES, 32'h3F80_0000});
    run_one("R6 sNaN flag", 3'd1, {ONES, 32'h4000_0000}, {ONES, 32'h7F80_0001});
    run_one("R7 unboxed",   3'd0, {32'h0, 32'h3F80_0000}, {ONES, 32'h40A0_0000});
    run_one("R8 boxed max", 3'd1, {ONES, 32'h0000_0001}, {ONES, 32'h8000_0001});
    run_one("R9 sgnj sNaN", 3'd2, {ONES, 32'h7F80_0ABC}, {ONES, 32'h8000_0000});
    run_one("R9 sgnjn",     3'd3, {ONES, 32'h3F80_0000}, {ONES, 32'h3F80_0000});
    run_one("R9 sgnjx",     3'd4, {ONES, 32'hBF80_0000}, {ONES, 32'hC000_0000});
    run_one("R10 -inf",     3'd5, {ONES, 32'hFF80_0000}, 64'd0);
    run_one("R10 sNaN",     3'd5, {ONES, 32'h7F80_0001}, 64'd0);
    run_one("R10 qNaN",     3'd5, {ONES, 32'h7FC0_0000}, 64'd0);
    run_one("R10 +sub",     3'd5, {ONES, 32'h0000_0001}, 64'd0);
    run_one("R10 -0",       3'd5, {ONES, 32'h8000_0000}, 64'd0);
    run_one("R12 op6",      3'd6, {ONES, 32'h3F80_0000}, {ONES, 32'h4000_0000});
    run_one("R12 op7",      3'd7, {ONES, 32'h7F80_0001}, {ONES, 32'h7F80_0001});

    // R1/R2: stall with a second operation waiting, then drain and accept together.
    @(negedge clk);
    in_valid = 1; in_op = 3'd0; in_a = {ONES, 32'h4040_0000}; in_b = {ONES, 32'h3F80_0000};
    out_ready = 0;
    e1 = model(3'd0, in_a, in_b);
    @(negedge clk);
    check("R1 captured", out_valid && {out_invalid, out_result} == e1, {out_invalid, out_result}, e1);
    in_op = 3'd1; in_a = {ONES, 32'h7F80_0002}; in_b = {ONES, 32'hC000_0000};
    e2 = model(3'd1, in_a, in_b);
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R2 stall ready low", in_ready == 0, {64'd0, in_ready}, 65'd0);
      check("R2 hold", out_valid && {out_invalid, out_result} == e1, {out_invalid, out_result}, e1);
      @(negedge clk);
    end
    out_ready = 1;
    #1;
    check("R1 ready on drain", in_ready == 1, {64'd0, in_ready}, 65'd1);
    @(negedge clk);
    in_valid = 0;
    check("R1 drain+accept", out_valid && {out_invalid, out_result} == e2, {out_invalid, out_result}, e2);
    @(negedge clk);
    check("R1 drained empty", out_valid == 0, {64'd0, out_valid}, 65'd0);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op = 3'($urandom % 8);
      logic [63:0] a = pick64(), b = pick64();
      if (($urandom % 6) == 0) b = {b[63:32], ~a[31], a[30:0]};
      case (op)
        3'd0, 3'd1: run_one("R3-R8 rand minmax", op, a, b);
        3'd2, 3'd3, 3'd4: run_one("R9 rand sgnj", op, a, b);
        3'd5: run_one("R10 rand class", op, a, b);
        default: run_one("R12 rand other", op, a, b);
      endcase
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule